// File: doc/BRIEF.md
# Base-Page Effective Address Generator

This block forms the 16-bit effective address for the one-byte-operand addressing modes of an 8-bit processor. In this processor the fixed page zero is replaced by a page chosen in software. The block holds that page number in its own base-page register. The accumulator writes the register through a one-cycle load strobe, and the current value is always visible on a read-back port.

When a start pulse arrives, the block samples the following:

- the mode code,
- the operand byte,
- the X, Y and Z index bytes,
- the stack pointer.

Modes that need no memory access return their address in the next cycle. The indirect modes fetch a two-byte pointer over a byte-wide read port and then add the post-index to it. That port answers one cycle after each request. The pointer locations are fixed at the start edge, so later changes to the inputs or to the base page do not disturb a request that is in progress.

Top module: `bpage_agen`

## Requirements
- R1: After reset the base page reads 0, `busy`, `mem_req` and `ea_valid` are low.
- R2: A cycle with `bp_load` high stores `bp_wdata`; `bp_rdata` shows the new value from the next cycle on.
- R3: Mode 0 (page direct, and reserved code 7) gives `ea = {bp, operand}` with `ea_valid` high in the cycle after the start edge and no memory request.
- R4: Modes 1 and 2 give `{bp, (operand + X) mod 256}` and `{bp, (operand + Y) mod 256}`, with the same one-cycle timing as R3.
- R5: Mode 3 reads the pointer low byte at `{bp, operand+X}` and the high byte at `{bp, operand+X+1}`, both offsets modulo 256; `ea` equals the pointer.
- R6: Mode 4 reads the pointer at `{bp, operand}` and `{bp, operand+1}` (offset wrapping in the page); `ea` is pointer + Y with full 16-bit carry.
- R7: Mode 5 reads the pointer as in R6 and adds Z; with Z equal to 0 the result is the bare pointer.
- R8: Mode 6 reads the pointer low byte at `stack_ptr + operand` and the high byte at the following address, both 16-bit modulo 2^16; `ea` is pointer + Y with 16-bit carry.
- R9: For an indirect mode accepted at edge k, `mem_req` is high with the low location after edge k and with the high location after edge k+1. `ea_valid` pulses after edge k+3. `busy` is high from edge k until edge k+3.
- R10: A start while `busy` is high is ignored, and input changes after the start edge do not change the result. A start in the cycle that `ea_valid` is high is accepted.
- R11: A base page load in the same cycle as a start, or during a fetch, does not change that request's addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bp_load | input | 1 | Write strobe for the base-page register |
| bp_wdata | input | 8 | New base page (from the accumulator) |
| bp_rdata | output | 8 | Current base page |
| start | input | 1 | Begin an address computation |
| mode | input | 3 | Addressing mode code (0..6, 7 as 0) |
| operand | input | 8 | Instruction operand byte |
| idx_x | input | 8 | X index |
| idx_y | input | 8 | Y index |
| idx_z | input | 8 | Z index |
| stack_ptr | input | 16 | Stack pointer |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte read address |
| mem_rdata | input | 8 | Read data, valid the cycle after a request |
| busy | output | 1 | A pointer fetch is in progress |
| ea_valid | output | 1 | One-cycle pulse: `ea` holds a result |
| ea | output | 16 | Effective address |

## Verification
Each mode is driven on a base page of zero and on non-zero pages. A nonzero page shows whether the page byte is placed in the high address byte.

Operands near 0xFF, together with large index values, separate in-page wrap from 16-bit carry. A Z of zero and a nonzero Z show whether Z is really added. A stack pointer close to 0xFFFF and one at a page boundary show whether the stack location is formed in 16 bits.

Three patterns probe the capture of inputs at the start edge:

- starts issued while busy,
- operand and index bytes scrambled during a fetch,
- base-page loads during a fetch.

Back-to-back starts placed in the result cycle check that the block returns to idle on time.

// File: rtl/bpage_agen_pkg.sv
package bpage_agen_pkg;
  typedef enum logic [2:0] {
    AM_PAGE   = 3'd0,
    AM_PAGE_X = 3'd1,
    AM_PAGE_Y = 3'd2,
    AM_IND_X  = 3'd3,
    AM_IND_Y  = 3'd4,
    AM_IND_Z  = 3'd5,
    AM_STK_Y  = 3'd6,
    AM_RSVD   = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LO   = 2'd1,
    SQ_HI   = 2'd2,
    SQ_FIN  = 2'd3
  } seq_e;

  function automatic logic needs_fetch(amode_e m);
    return (m == AM_IND_X) || (m == AM_IND_Y) || (m == AM_IND_Z) || (m == AM_STK_Y);
  endfunction
endpackage

// File: rtl/bpage_reg.sv
module bpage_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load) q_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/bpage_loc_calc.sv
module bpage_loc_calc
  import bpage_agen_pkg::*;
#(
  parameter int DW       = 8,
  parameter bit STACK_EN = 1'b1,
  localparam int AW      = 2 * DW
) (
  input  amode_e        mode,
  input  logic [DW-1:0] operand,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic [DW-1:0] idx_z,
  input  logic [DW-1:0] bp,
  input  logic [AW-1:0] stack_ptr,
  output logic [AW-1:0] page_ea,
  output logic [AW-1:0] loc_lo,
  output logic [AW-1:0] loc_hi,
  output logic [DW-1:0] post_idx,
  output logic          fetch,
  output logic          in_page
);
  logic [DW-1:0] off_direct;
  logic [DW-1:0] off_ptr;
  logic [DW-1:0] off_ptr_nx;

  always_comb begin
    unique case (mode)
      AM_PAGE_X: off_direct = operand + idx_x;
      AM_PAGE_Y: off_direct = operand + idx_y;
      default:   off_direct = operand;
    endcase
    off_ptr    = (mode == AM_IND_X) ? operand + idx_x : operand;
    off_ptr_nx = off_ptr + 1'b1;
    page_ea    = {bp, off_direct};
    fetch      = needs_fetch(mode);
    unique case (mode)
      AM_IND_Y, AM_STK_Y: post_idx = idx_y;
      AM_IND_Z:           post_idx = idx_z;
      default:            post_idx = '0;
    endcase
  end

  generate
    if (STACK_EN) begin : g_stack
      logic [AW-1:0] stk_loc;
      assign stk_loc = stack_ptr + {{DW{1'b0}}, operand};
      always_comb begin
        in_page = (mode != AM_STK_Y);
        loc_lo  = in_page ? {bp, off_ptr}    : stk_loc;
        loc_hi  = in_page ? {bp, off_ptr_nx} : stk_loc + 1'b1;
      end
    end else begin : g_nostack
      logic [AW-1:0] unused_sp;
      assign unused_sp = stack_ptr;
      always_comb begin
        in_page = 1'b1;
        loc_lo  = {bp, off_ptr};
        loc_hi  = {bp, off_ptr_nx};
      end
    end
  endgenerate
endmodule

// File: rtl/bpage_seq.sv
module bpage_seq
  import bpage_agen_pkg::*;
#(
  parameter int DW  = 8,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          fetch,
  input  logic          in_page,
  input  logic [AW-1:0] page_ea,
  input  logic [AW-1:0] loc_lo,
  input  logic [AW-1:0] loc_hi,
  input  logic [DW-1:0] post_idx,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          busy,
  output logic          ea_valid,
  output logic [AW-1:0] ea
);
  seq_e          state, state_d;
  logic [AW-1:0] lo_q, hi_q;
  logic [DW-1:0] pidx_q, plo_q;
  logic          page_q;
  logic          cap_en, plo_en, ea_en;
  logic [AW-1:0] ea_d;

  always_comb begin
    state_d = state;
    cap_en  = 1'b0;
    plo_en  = 1'b0;
    ea_en   = 1'b0;
    ea_d    = ea;
    unique case (state)
      SQ_IDLE: if (start) begin
        if (fetch) begin
          state_d = SQ_LO;
          cap_en  = 1'b1;
        end else begin
          ea_en = 1'b1;
          ea_d  = page_ea;
        end
      end
      SQ_LO:  state_d = SQ_HI;
      SQ_HI: begin
        state_d = SQ_FIN;
        plo_en  = 1'b1;
      end
      SQ_FIN: begin
        state_d = SQ_IDLE;
        ea_en   = 1'b1;
        ea_d    = {mem_rdata, plo_q} + {{DW{1'b0}}, pidx_q};
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      lo_q     <= '0;
      hi_q     <= '0;
      pidx_q   <= '0;
      page_q   <= 1'b1;
      plo_q    <= '0;
      ea       <= '0;
      ea_valid <= 1'b0;
    end else begin
      state    <= state_d;
      ea_valid <= ea_en;
      if (cap_en) begin
        lo_q   <= loc_lo;
        hi_q   <= loc_hi;
        pidx_q <= post_idx;
        page_q <= in_page;
      end
      if (plo_en) plo_q <= mem_rdata;
      if (ea_en)  ea    <= ea_d;
    end
  end

  assign mem_req  = (state == SQ_LO) || (state == SQ_HI);
  assign mem_addr = (state == SQ_HI) ? hi_q : lo_q;
  assign busy     = (state != SQ_IDLE);

  assert_req_inside_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
  assert_lo_then_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_LO) |=> (state == SQ_HI) && mem_req);
  assert_result_after_fetch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_FIN) |=> ea_valid && !busy);
  assert_direct_no_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !fetch) |=> ea_valid && !mem_req && !busy);
  assert_hi_same_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_LO && page_q) |=> mem_addr[AW-1:DW] == $past(mem_addr[AW-1:DW]));
  assert_stack_next_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_LO && !page_q) |=> mem_addr == $past(mem_addr) + 1'b1);
  assert_hold_while_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state != SQ_FIN) |=> $stable(lo_q) && $stable(hi_q) && $stable(pidx_q));
endmodule

// File: rtl/bpage_agen.sv
module bpage_agen
  import bpage_agen_pkg::*;
#(
  parameter int DW       = 8,
  parameter bit STACK_EN = 1'b1,
  localparam int AW      = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bp_load,
  input  logic [DW-1:0] bp_wdata,
  output logic [DW-1:0] bp_rdata,
  input  logic          start,
  input  logic [2:0]    mode,
  input  logic [DW-1:0] operand,
  input  logic [DW-1:0] idx_x,
  input  logic [DW-1:0] idx_y,
  input  logic [DW-1:0] idx_z,
  input  logic [AW-1:0] stack_ptr,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          ea_valid,
  output logic [AW-1:0] ea
);
  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic [DW-1:0] bp_q;
  logic [AW-1:0] page_ea, loc_lo, loc_hi;
  logic [DW-1:0] post_idx;
  logic          fetch, in_page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  bpage_reg #(.DW(DW)) u_bp (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (bp_load),
    .wdata (bp_wdata),
    .q     (bp_q)
  );
  assign bp_rdata = bp_q;

  bpage_loc_calc #(.DW(DW), .STACK_EN(STACK_EN)) u_loc (
    .mode      (amode_e'(mode)),
    .operand   (operand),
    .idx_x     (idx_x),
    .idx_y     (idx_y),
    .idx_z     (idx_z),
    .bp        (bp_q),
    .stack_ptr (stack_ptr),
    .page_ea   (page_ea),
    .loc_lo    (loc_lo),
    .loc_hi    (loc_hi),
    .post_idx  (post_idx),
    .fetch     (fetch),
    .in_page   (in_page)
  );

  bpage_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .fetch     (fetch),
    .in_page   (in_page),
    .page_ea   (page_ea),
    .loc_lo    (loc_lo),
    .loc_hi    (loc_hi),
    .post_idx  (post_idx),
    .mem_rdata (mem_rdata),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .busy      (busy),
    .ea_valid  (ea_valid),
    .ea        (ea)
  );

  assert_bp_load_visible_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    bp_load |=> bp_rdata == $past(bp_wdata));
  assert_bp_holds_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !bp_load |=> $stable(bp_rdata));
  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ea_valid && busy) |-> 1'b0);
endmodule

// File: tb/bpage_agen_test.sv
module bpage_agen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bp_load = 1'b0;
  logic [7:0]  bp_wdata = 8'h00;
  logic [7:0]  bp_rdata;
  logic        start = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [7:0]  operand = 8'h00, idx_x = 8'h00, idx_y = 8'h00, idx_z = 8'h00;
  logic [15:0] stack_ptr = 16'h01FF;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic        busy, ea_valid;
  logic [15:0] ea;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit checking = 1'b0;
  string tag = "R3";

  always #5 clk = ~clk;

  bpage_agen uut (
    .clk(clk), .rst_n(rst_n), .bp_load(bp_load), .bp_wdata(bp_wdata), .bp_rdata(bp_rdata),
    .start(start), .mode(mode), .operand(operand), .idx_x(idx_x), .idx_y(idx_y),
    .idx_z(idx_z), .stack_ptr(stack_ptr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .busy(busy), .ea_valid(ea_valid), .ea(ea)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ (a[15:8] * 8'd13) ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_req) mem_rdata <= memf(mem_addr);

  // behavioural reference model
  int          ph;
  logic [7:0]  mbp, t8;
  logic [15:0] la, ha, eea;
  logic [7:0]  pidx;
  logic        ev;
  string       mtag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; mbp = 8'h00; ev = 1'b0; la = 16'h0; ha = 16'h0; eea = 16'h0; pidx = 8'h0;
      mtag = "R1";
    end else begin
      ev = 1'b0;
      case (ph)
        0: if (start) begin
          mtag = tag;
          case (mode)
            3'd1: begin t8 = operand + idx_x; eea = {mbp, t8}; ev = 1'b1; end
            3'd2: begin t8 = operand + idx_y; eea = {mbp, t8}; ev = 1'b1; end
            3'd3: begin t8 = operand + idx_x; la = {mbp, t8}; t8 = t8 + 8'd1; ha = {mbp, t8};
                        pidx = 8'd0; ph = 1; end
            3'd4, 3'd5: begin t8 = operand; la = {mbp, t8}; t8 = t8 + 8'd1; ha = {mbp, t8};
                        pidx = (mode == 3'd4) ? idx_y : idx_z; ph = 1; end
            3'd6: begin la = stack_ptr + {8'd0, operand}; ha = la + 16'd1; pidx = idx_y; ph = 1; end
            default: begin eea = {mbp, operand}; ev = 1'b1; end
          endcase
        end
        1: ph = 2;
        2: ph = 3;
        default: begin ph = 0; ev = 1'b1; eea = {memf(ha), memf(la)} + {8'd0, pidx}; end
      endcase
      if (bp_load) mbp = bp_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (checking) begin
    chk(bp_rdata == mbp, "R2", "bp_rdata", {8'd0, bp_rdata}, {8'd0, mbp});
    chk(busy == (ph != 0), "R9", "busy", {15'd0, busy}, {15'd0, ph != 0});
    chk(mem_req == (ph == 1 || ph == 2), "R9", "mem_req", {15'd0, mem_req},
        {15'd0, ph == 1 || ph == 2});
    if (ph == 1) chk(mem_addr == la, mtag, "ptr low location", mem_addr, la);
    if (ph == 2) chk(mem_addr == ha, mtag, "ptr high location", mem_addr, ha);
    chk(ea_valid == ev, "R9", "ea_valid", {15'd0, ea_valid}, {15'd0, ev});
    if (ev) chk(ea == eea, mtag, "ea", ea, eea);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic setbp(input logic [7:0] v);
    @(negedge clk); #1; bp_load = 1'b1; bp_wdata = v;
    @(negedge clk); #1; bp_load = 1'b0;
  endtask

  task automatic go(input string t, input logic [2:0] m, input logic [7:0] op,
                    input logic [7:0] x, input logic [7:0] y, input logic [7:0] z,
                    input logic [15:0] sp);
    @(negedge clk); #1;
    tag = t; start = 1'b1; mode = m; operand = op; idx_x = x; idx_y = y; idx_z = z; stack_ptr = sp;
    @(negedge clk); #1;
    start = 1'b0; operand = ~op; idx_x = x ^ 8'h5C; idx_y = y ^ 8'hA3; idx_z = z + 8'd9;
    stack_ptr = ~sp;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    chk(bp_rdata == 8'h00, "R1", "bp after reset", {8'd0, bp_rdata}, 16'h0000);
    chk(!busy && !mem_req && !ea_valid, "R1", "idle after reset",
        {13'd0, busy, mem_req, ea_valid}, 16'h0000);
    checking = 1'b1;

    go("R3", 3'd0, 8'h42, 8'h11, 8'h22, 8'h33, 16'h01F0);
    go("R7", 3'd5, 8'h10, 8'h00, 8'h00, 8'h00, 16'h01F0);
    setbp(8'h3C);
    go("R3", 3'd0, 8'h9A, 8'h00, 8'h00, 8'h00, 16'h0100);
    go("R3", 3'd7, 8'h05, 8'h00, 8'h00, 8'h00, 16'h0100);
    go("R4", 3'd1, 8'hF0, 8'h20, 8'h00, 8'h00, 16'h0100);
    go("R4", 3'd2, 8'h80, 8'h00, 8'h7F, 8'h00, 16'h0100);
    go("R4", 3'd2, 8'hFF, 8'h00, 8'h01, 8'h00, 16'h0100);
    go("R5", 3'd3, 8'h10, 8'h05, 8'h00, 8'h00, 16'h0100);
    go("R5", 3'd3, 8'hFE, 8'h01, 8'h00, 8'h00, 16'h0100);
    go("R5", 3'd3, 8'hF0, 8'h20, 8'h00, 8'h00, 16'h0100);
    go("R6", 3'd4, 8'h20, 8'h00, 8'h04, 8'h00, 16'h0100);
    go("R6", 3'd4, 8'hFF, 8'h00, 8'hFF, 8'h00, 16'h0100);
    go("R7", 3'd5, 8'h44, 8'h00, 8'h00, 8'h00, 16'h0100);
    go("R7", 3'd5, 8'hFF, 8'h00, 8'h00, 8'hF1, 16'h0100);
    go("R8", 3'd6, 8'h01, 8'h00, 8'h03, 8'h00, 16'h01FF);
    go("R8", 3'd6, 8'h01, 8'h00, 8'hFF, 8'h00, 16'hFFFE);
    go("R8", 3'd6, 8'h80, 8'h00, 8'h00, 8'h00, 16'h12F0);
    setbp(8'hE1);
    go("R6", 3'd4, 8'h7F, 8'h00, 8'hC0, 8'h00, 16'h0100);

    // R10: starts during a fetch are ignored
    @(negedge clk); #1;
    tag = "R10"; start = 1'b1; mode = 3'd4; operand = 8'h31; idx_y = 8'h09;
    @(negedge clk); #1; mode = 3'd0; operand = 8'h77; idx_y = 8'h55;
    @(negedge clk); #1; mode = 3'd1;
    @(negedge clk); #1; start = 1'b0;
    repeat (4) @(negedge clk);

    // R10: start accepted in the result cycle (back to back)
    @(negedge clk); #1; tag = "R10"; start = 1'b1; mode = 3'd6; operand = 8'h02;
    stack_ptr = 16'h01FD; idx_y = 8'h01;
    @(negedge clk); #1; start = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk); #1;
    start = 1'b1; mode = 3'd2; operand = 8'h10; idx_y = 8'h05;
    @(negedge clk); #1; start = 1'b1; mode = 3'd5; operand = 8'h60; idx_z = 8'h02;
    @(negedge clk); #1; start = 1'b0;
    repeat (5) @(negedge clk);

    // R11: base page loaded with start and during the fetch
    @(negedge clk); #1; tag = "R11"; start = 1'b1; mode = 3'd5; operand = 8'hA0;
    idx_z = 8'h01; bp_load = 1'b1; bp_wdata = 8'h07;
    @(negedge clk); #1; start = 1'b0; bp_wdata = 8'h99;
    @(negedge clk); #1; bp_wdata = 8'h4D;
    @(negedge clk); #1; bp_load = 1'b0;
    repeat (4) @(negedge clk);
    go("R11", 3'd0, 8'h12, 8'h00, 8'h00, 8'h00, 16'h0100);

    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule